// File: doc/BRIEF.md
# General-Purpose Dual-Mode Timer

This block is a 32-bit up-counting timer that a processor reaches through a small single-clock register bus. The counter advances once per tick. A tick is either every clock or one clock out of 2^(n+1), where n is a 3-bit divider select. When the counter runs past all ones, it either reloads from a reload register and keeps running, or it wraps to zero and stops. A compare register can raise a match event. The same block can also timestamp edges on an external pin into a capture register.

Three events feed a flag register: match, overflow and capture. Software acknowledges a flag by writing a one to its bit. Two mask registers form the interrupt request and the wake-up request from those flags. Overflow and match events can also drive an output pin. In pulse mode the pin leaves its idle level for one clock. In toggle mode the pin changes level on each event. Writing any value to a restart register copies the reload value into the counter.

Two state machines sit inside. The run machine has states HALT and RUN. It goes HALT→RUN on a control write with the run bit set. It goes RUN→HALT on a control write with the run bit clear, or on a one-shot overflow. The pin machine has states REST and ACTIVE. In pulse mode it goes REST→ACTIVE on a selected event and ACTIVE→REST on the next clock without an event. In toggle mode each selected event flips it between REST and ACTIVE. Whenever no output trigger is selected it is forced to REST.

Top module: `gp_timer_core`

## Requirements
- R1: After reset, every register reads as zero, irq and wake are low, pin_out is 0 and pin_oe is 1. Register addresses are: control 0x00, counter 0x04, reload 0x08, restart 0x0C, compare 0x10, capture 0x14 (read only), flags 0x18, irq mask 0x1C, wake mask 0x20.
- R2: Counter writes set the count directly and reads return it. Control bit 0 written as 1 starts the timer, and control bit 0 reads back 1 while running. While running, the count rises by one per tick; while halted it holds.
- R3: With control bit 2 set, a tick occurs once every 2^(n+1) clocks, where n is control bits 5:3. With bit 2 clear, a tick occurs every clock. A control write restarts the divider phase.
- R4: With control bit 1 (auto-reload) set, a tick at count 0xFFFFFFFF loads the reload value and the timer keeps running.
- R5: With control bit 1 clear, a tick at count 0xFFFFFFFF wraps the count to 0 and clears the run state.
- R6: A write of any value to the restart register copies the reload register into the counter.
- R7: With control bit 6 set, a tick whose result equals the compare register sets flag bit 0. With bit 6 clear, no match flag is raised.
- R8: Flag bits are: bit 0 match, bit 1 overflow, bit 2 capture. A bit is set by its event. A bus write clears exactly the bits written as 1; a bit written as 0 is unaffected.
- R9: irq is the OR of flags AND irq mask; wake is the OR of flags AND wake mask.
- R10: Pulse mode (control bit 8 = 0): a selected event drives pin_out to the inverse of the idle level (control bit 7) for one clock, starting the clock after the event.
- R11: Toggle mode (control bit 8 = 1): each selected event inverts pin_out, starting the clock after the event.
- R12: Output trigger select is control bits 10:9: 00 none, 01 overflow, 10 overflow or match, 11 none. With none selected, pin_out stays at the idle level. pin_oe is the inverse of control bit 14.
- R13: With control bit 14 set, an edge on cap_in selected by control bits 12:11 (01 rising, 10 falling, 11 both) loads the count into the capture register and sets flag bit 2. The capture lands on the third clock edge after cap_in changes.
- R14: With control bit 13 (hold) set, no capture occurs while flag bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| cap_in | input | 1 | Asynchronous capture pin input |
| pin_out | output | 1 | Timer output level |
| pin_oe | output | 1 | Output enable for the pin |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The hardest situation to reach from the ports is counter overflow: from zero it needs 2^32 ticks. The stimulus writes the counter a few steps below all ones, then starts the timer. This reaches the one-shot stop, the auto-reload and the overflow-driven pin events within a handful of clocks. The divider sweep covers all eight settings plus the bypass, and checks the exact clock on which the first tick lands. Capture is exercised with the counter halted at known values, so every captured value is exact.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic {T_HALT, T_RUN} run_state_t;
    typedef enum logic {O_REST, O_ACTIVE} pin_state_t;

    localparam int unsigned A_CTRL    = 'h00;
    localparam int unsigned A_COUNT   = 'h04;
    localparam int unsigned A_RELOAD  = 'h08;
    localparam int unsigned A_RESTART = 'h0C;
    localparam int unsigned A_CMP     = 'h10;
    localparam int unsigned A_CAP     = 'h14;
    localparam int unsigned A_FLAGS   = 'h18;
    localparam int unsigned A_IRQEN   = 'h1C;
    localparam int unsigned A_WAKEEN  = 'h20;

    localparam int SEL_W    = 3;
    localparam int C_RUN    = 0;
    localparam int C_AUTO   = 1;
    localparam int C_DIVEN  = 2;
    localparam int C_DIVSEL = 3;
    localparam int C_CMPEN  = C_DIVSEL + SEL_W;
    localparam int C_IDLE   = C_CMPEN + 1;
    localparam int C_TOGGLE = C_IDLE + 1;
    localparam int C_TRIG   = C_TOGGLE + 1;
    localparam int C_EDGE   = C_TRIG + 2;
    localparam int C_HOLD   = C_EDGE + 2;
    localparam int C_PININ  = C_HOLD + 1;
    localparam int CTRL_W   = C_PININ + 1;

    localparam int F_MATCH  = 0;
    localparam int F_OVF    = 1;
    localparam int F_CAP    = 2;
    localparam int FLAG_W   = 3;

endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    input  logic            div_en,
    input  logic [SELW-1:0] sel,
    output logic            tick
);
    localparam int PW = 2 ** SELW;
    localparam logic [SELW-1:0] TOPSH = SELW'(PW - 1);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] limit;

    assign limit = {PW{1'b1}} >> (TOPSH - sel);
    assign tick  = en && (!div_en || (pcnt == limit));

    always_ff @(posedge clk) begin
        if (!rst_n)                  pcnt <= '0;
        else if (clr || !en || tick) pcnt <= '0;
        else                         pcnt <= pcnt + 1'b1;
    end

    // R3
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && div_en) |-> (pcnt <= limit));

endmodule

// File: rtl/gpt_count.sv
module gpt_count
    import gpt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_wr,
    input  logic         run_req,
    input  logic         auto_rl,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] wdata,
    input  logic         restart,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         running,
    output logic         ovf_ev
);
    run_state_t st, st_nx;
    logic wrap;

    assign wrap    = tick && (count == {W{1'b1}});
    assign ovf_ev  = wrap;
    assign running = (st == T_RUN);

    always_comb begin
        st_nx = st;
        unique case (st)
            T_HALT: if (ctrl_wr && run_req) st_nx = T_RUN;
            T_RUN: begin
                if (ctrl_wr)              st_nx = run_req ? T_RUN : T_HALT;
                else if (wrap && !auto_rl) st_nx = T_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= T_HALT;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (cnt_wr)  count <= wdata;
        else if (restart) count <= reload;
        else if (tick)    count <= wrap ? (auto_rl ? reload : '0) : count + 1'b1;
    end

    // R2
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !tick);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr && !restart) |=> $stable(count));
    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !auto_rl && !ctrl_wr) |=> !running);
    // R4
    autoreload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && auto_rl && !cnt_wr && !restart) |=> (count == $past(reload)));

endmodule

// File: rtl/gpt_outpin.sv
module gpt_outpin
    import gpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_lvl,
    input  logic       toggle,
    input  logic [1:0] trig,
    input  logic       ovf_ev,
    input  logic       match_ev,
    output logic       pin
);
    pin_state_t st, st_nx;
    logic armed, ev;

    assign armed = (trig == 2'b01) || (trig == 2'b10);
    assign ev    = ((trig == 2'b01) && ovf_ev) ||
                   ((trig == 2'b10) && (ovf_ev || match_ev));

    always_comb begin
        st_nx = st;
        if (!armed) begin
            st_nx = O_REST;
        end else begin
            unique case (st)
                O_REST:   if (ev) st_nx = O_ACTIVE;
                O_ACTIVE: begin
                    if (toggle) st_nx = ev ? O_REST : O_ACTIVE;
                    else        st_nx = ev ? O_ACTIVE : O_REST;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= O_REST;
        else        st <= st_nx;
    end

    always_comb pin = (st == O_ACTIVE) ^ idle_lvl;

    // R10
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == O_ACTIVE && !toggle && !ev) |=> (st == O_REST));
    // R12
    unarmed_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && $past(!armed)) |-> (st == O_REST));

endmodule

// File: rtl/gp_timer_core.sv
module gp_timer_core
    import gpt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              cap_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq,
    output logic              wake
);
    logic [CTRL_W-1:1] ctrl_q;
    logic [CNT_W-1:0]  reload_q, cmp_q, cap_q, count;
    logic [FLAG_W-1:0] flags_q, irqen_q, waken_q, set_v, clr_v;
    logic [2:0]        cs;
    logic wr, ctrl_wr, cnt_wr, restart, flags_wr;
    logic tick, running, ovf_ev, match_ev, rise, fall, cap_hit;

    assign wr       = bus_sel && bus_wr;
    assign ctrl_wr  = wr && (bus_addr == ADDR_W'(A_CTRL));
    assign cnt_wr   = wr && (bus_addr == ADDR_W'(A_COUNT));
    assign restart  = wr && (bus_addr == ADDR_W'(A_RESTART));
    assign flags_wr = wr && (bus_addr == ADDR_W'(A_FLAGS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            cmp_q    <= '0;
            irqen_q  <= '0;
            waken_q  <= '0;
        end else if (wr) begin
            if (bus_addr == ADDR_W'(A_CTRL))   ctrl_q   <= bus_wdata[CTRL_W-1:1];
            if (bus_addr == ADDR_W'(A_RELOAD)) reload_q <= bus_wdata;
            if (bus_addr == ADDR_W'(A_CMP))    cmp_q    <= bus_wdata;
            if (bus_addr == ADDR_W'(A_IRQEN))  irqen_q  <= bus_wdata[FLAG_W-1:0];
            if (bus_addr == ADDR_W'(A_WAKEEN)) waken_q  <= bus_wdata[FLAG_W-1:0];
        end
    end

    gpt_prescale #(.SELW(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(running), .clr(ctrl_wr),
        .div_en(ctrl_q[C_DIVEN]), .sel(ctrl_q[C_DIVSEL +: SEL_W]), .tick(tick)
    );

    gpt_count #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .run_req(bus_wdata[C_RUN]),
        .auto_rl(ctrl_q[C_AUTO]), .tick(tick), .cnt_wr(cnt_wr), .wdata(bus_wdata),
        .restart(restart), .reload(reload_q), .count(count), .running(running),
        .ovf_ev(ovf_ev)
    );

    assign match_ev = tick && ctrl_q[C_CMPEN] && ((count + CNT_W'(1)) == cmp_q);

    gpt_outpin u_pin (
        .clk(clk), .rst_n(rst_n), .idle_lvl(ctrl_q[C_IDLE]), .toggle(ctrl_q[C_TOGGLE]),
        .trig(ctrl_q[C_TRIG +: 2]), .ovf_ev(ovf_ev), .match_ev(match_ev), .pin(pin_out)
    );
    assign pin_oe = !ctrl_q[C_PININ];

    always_ff @(posedge clk) begin
        if (!rst_n) cs <= '0;
        else        cs <= {cs[1:0], cap_in};
    end
    assign rise    = cs[1] && !cs[2];
    assign fall    = !cs[1] && cs[2];
    assign cap_hit = ctrl_q[C_PININ] &&
                     ((ctrl_q[C_EDGE] && rise) || (ctrl_q[C_EDGE+1] && fall)) &&
                     !(ctrl_q[C_HOLD] && flags_q[F_CAP]);

    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_hit) cap_q <= count;
    end

    always_comb begin
        set_v          = '0;
        set_v[F_MATCH] = match_ev;
        set_v[F_OVF]   = ovf_ev;
        set_v[F_CAP]   = cap_hit;
        clr_v          = flags_wr ? bus_wdata[FLAG_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_v) | set_v;
    end

    assign irq  = |(flags_q & irqen_q);
    assign wake = |(flags_q & waken_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == ADDR_W'(A_CTRL))   bus_rdata = CNT_W'({ctrl_q, running});
            if (bus_addr == ADDR_W'(A_COUNT))  bus_rdata = count;
            if (bus_addr == ADDR_W'(A_RELOAD)) bus_rdata = reload_q;
            if (bus_addr == ADDR_W'(A_CMP))    bus_rdata = cmp_q;
            if (bus_addr == ADDR_W'(A_CAP))    bus_rdata = cap_q;
            if (bus_addr == ADDR_W'(A_FLAGS))  bus_rdata = CNT_W'(flags_q);
            if (bus_addr == ADDR_W'(A_IRQEN))  bus_rdata = CNT_W'(irqen_q);
            if (bus_addr == ADDR_W'(A_WAKEEN)) bus_rdata = CNT_W'(waken_q);
        end
    end

    // R8
    ovf_flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[F_OVF] && !(flags_wr && bus_wdata[F_OVF])) |=> flags_q[F_OVF]);
    // R13
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (cap_q == $past(count)));
    // R14
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[C_HOLD] && flags_q[F_CAP]) |=> $stable(cap_q));

endmodule

// File: tb/sim_gp_timer_core.sv
`timescale 1ns/100ps
module sim_gp_timer_core;
    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0, cap_in = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic pin_out, pin_oe, irq, wake;
    int total = 0, bad = 0;
    logic [31:0] v;

    gp_timer_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .wake(wake)
    );

    always #2.5 clk = ~clk;

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chkreg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chkreg("R1 ctrl", 8'h00, 0);
        chkreg("R1 count", 8'h04, 0);
        chkreg("R1 flags", 8'h18, 0);
        chkreg("R1 cap", 8'h14, 0);
        chk("R1 irq/wake/pin/oe", {28'd0, irq, wake, pin_out, pin_oe}, 32'h1);

        // R2 direct counter write
        wr(8'h04, 32'h0000_002A);
        chkreg("R2 count write", 8'h04, 32'h2A);
        waitc(4);
        chkreg("R2 halted holds", 8'h04, 32'h2A);

        // R3 divider bypass: tick every clock
        wr(8'h04, 0);
        wr(8'h00, 32'h1);
        waitc(5);
        chkreg("R2 run count", 8'h04, 5);
        chkreg("R2 run bit", 8'h00, 32'h1);
        // R3 sweep of all divider settings
        for (int s = 0; s < 8; s++) begin
            int d;
            d = 1 << (s + 1);
            wr(8'h00, 0);
            wr(8'h04, 0);
            wr(8'h00, 32'h1 | 32'h4 | (s << 3));
            waitc(d - 1);
            chkreg("R3 before first tick", 8'h04, 0);
            waitc(1);
            chkreg("R3 first tick", 8'h04, 1);
            waitc(d + d / 2);
            chkreg("R3 second tick", 8'h04, 2);
        end

        // R4 auto-reload overflow
        wr(8'h00, 0);
        wr(8'h18, 7);
        wr(8'h08, 32'h1234);
        wr(8'h04, 32'hFFFF_FFF0);
        wr(8'h00, 32'h3);
        waitc(15);
        chkreg("R4 top", 8'h04, 32'hFFFF_FFFF);
        chkreg("R8 no flag yet", 8'h18, 0);
        waitc(1);
        chkreg("R4 reloaded", 8'h04, 32'h1234);
        chkreg("R8 ovf flag", 8'h18, 2);
        chkreg("R4 still running", 8'h00, 32'h3);
        waitc(3);
        chkreg("R4 continues", 8'h04, 32'h1237);

        // R5 one-shot overflow
        wr(8'h00, 0);
        wr(8'h18, 7);
        wr(8'h04, 32'hFFFF_FFFE);
        wr(8'h00, 32'h1);
        waitc(2);
        chkreg("R5 wrapped", 8'h04, 0);
        chkreg("R5 stopped", 8'h00, 0);
        chkreg("R5 ovf flag", 8'h18, 2);
        waitc(5);
        chkreg("R5 stays", 8'h04, 0);

        // R6 restart with arbitrary values
        wr(8'h08, 32'hABCD);
        wr(8'h04, 5);
        wr(8'h0C, 0);
        chkreg("R6 restart 0", 8'h04, 32'hABCD);
        wr(8'h04, 9);
        wr(8'h0C, 32'hFFFF_FFFF);
        chkreg("R6 restart ones", 8'h04, 32'hABCD);

        // R7 compare match
        wr(8'h18, 7);
        wr(8'h10, 32'h100);
        wr(8'h04, 32'hF0);
        wr(8'h00, 32'h41);
        waitc(15);
        chkreg("R7 not yet", 8'h18, 0);
        waitc(1);
        chkreg("R7 match flag", 8'h18, 1);
        chkreg("R7 count", 8'h04, 32'h100);
        wr(8'h00, 0);
        wr(8'h18, 7);
        wr(8'h04, 32'hF0);
        wr(8'h00, 32'h1);
        waitc(16);
        chkreg("R7 compare off", 8'h18, 0);
        wr(8'h00, 0);

        // R8 write-one-to-clear
        wr(8'h18, 7);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h00, 32'h1);
        waitc(1);
        chkreg("R8 set", 8'h18, 2);
        wr(8'h18, 5);
        chkreg("R8 zero bits ignored", 8'h18, 2);
        wr(8'h18, 2);
        chkreg("R8 cleared", 8'h18, 0);

        // R9 irq / wake masking
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h00, 32'h1);
        waitc(1);
        wr(8'h1C, 1);
        chk("R9 irq masked", irq, 0);
        wr(8'h1C, 2);
        chk("R9 irq on", irq, 1);
        wr(8'h20, 4);
        chk("R9 wake masked", wake, 0);
        wr(8'h20, 2);
        chk("R9 wake on", wake, 1);
        wr(8'h18, 7);
        chk("R9 irq drops", irq, 0);

        // R10 pulse on overflow, idle low
        wr(8'h08, 0);
        wr(8'h04, 32'hFFFF_FFFE);
        wr(8'h00, 32'h201);
        waitc(1);
        chk("R10 before event", pin_out, 0);
        waitc(1);
        chk("R10 pulse", pin_out, 1);
        waitc(1);
        chk("R10 pulse ends", pin_out, 0);
        chk("R12 oe", pin_oe, 1);
        // R10 idle high
        wr(8'h00, 32'h80);
        chk("R10 idle high", pin_out, 1);
        wr(8'h04, 32'hFFFF_FFFE);
        wr(8'h00, 32'h281);
        waitc(2);
        chk("R10 low pulse", pin_out, 0);
        waitc(1);
        chk("R10 back high", pin_out, 1);
        // R12 no trigger selected
        wr(8'h04, 32'hFFFF_FFFE);
        wr(8'h00, 32'h1);
        waitc(2);
        chk("R12 trig none", pin_out, 0);
        // R12 match trigger vs overflow-only trigger
        wr(8'h10, 32'h10);
        wr(8'h04, 32'hE);
        wr(8'h00, 32'h441);
        waitc(2);
        chk("R12 match pulse", pin_out, 1);
        waitc(1);
        chk("R10 match pulse ends", pin_out, 0);
        wr(8'h00, 0);
        wr(8'h04, 32'hE);
        wr(8'h00, 32'h241);
        waitc(2);
        chk("R12 ovf-only ignores match", pin_out, 0);
        wr(8'h00, 0);

        // R11 toggle mode with auto-reload every two ticks
        wr(8'h08, 32'hFFFF_FFFE);
        wr(8'h04, 32'hFFFF_FFFE);
        wr(8'h00, 32'h303);
        waitc(1);
        chk("R11 start", pin_out, 0);
        waitc(1);
        chk("R11 first toggle", pin_out, 1);
        waitc(1);
        chk("R11 holds", pin_out, 1);
        waitc(1);
        chk("R11 second toggle", pin_out, 0);
        wr(8'h00, 0);

        // R13 capture rising edge
        wr(8'h00, 32'h4800);
        chk("R12 oe off", pin_oe, 0);
        wr(8'h18, 7);
        wr(8'h04, 32'h55);
        cap_in = 1;
        waitc(2);
        chkreg("R13 not yet", 8'h14, 0);
        waitc(1);
        chkreg("R13 rise capture", 8'h14, 32'h55);
        chkreg("R13 cap flag", 8'h18, 4);
        wr(8'h04, 32'h66);
        cap_in = 0;
        waitc(4);
        chkreg("R13 fall ignored", 8'h14, 32'h55);
        // R13 falling edge select
        wr(8'h00, 32'h5000);
        wr(8'h18, 7);
        wr(8'h04, 32'h77);
        cap_in = 1;
        waitc(4);
        chkreg("R13 rise ignored", 8'h14, 32'h55);
        cap_in = 0;
        waitc(4);
        chkreg("R13 fall capture", 8'h14, 32'h77);
        // R14 hold while flag set
        wr(8'h00, 32'h7800);
        wr(8'h04, 32'h88);
        cap_in = 1;
        waitc(4);
        chkreg("R14 held", 8'h14, 32'h77);
        wr(8'h18, 4);
        wr(8'h04, 32'h99);
        cap_in = 0;
        waitc(4);
        chkreg("R14 released", 8'h14, 32'h99);

        rd(8'h18, v);
        chk("R13 flag after capture", v, 4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule